// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block is the digital control side of a multi-channel successive-approximation converter. It holds two programmable lists of channels. The first is a regular list of up to 16 ranked slots. The second is a higher-priority injected list of up to 4 slots. The block walks these lists according to the selected mode, which is one-shot, continuous, scan or partial (short bursts). For each conversion it sends the analog core a channel number, that channel's sampling-time code and a one-cycle start strobe. It then waits for the core's done pulse and files the result.

Regular results land in one shared result register. Each injected slot keeps its own result register. Completion flags, an overrun flag, a transfer-request pulse for a DMA engine and one combined interrupt line tell the rest of the system about new data. Conversions start from a software start bit or from the rising edge of an external trigger line. The injected list can also run on its own after each regular pass. An injected start breaks into a regular conversion in progress, and the regular list carries on afterwards from the slot that was cut off.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With scan, partial and continuous modes all off, a start converts the channel in regular slot 0 once, sets `eoc`, and issues no further `adc_start`.
- R2: With `cont_en`=1 a regular pass restarts by itself with no new start. In scan mode, the next conversion after slot `reg_len` is slot 0.
- R3: With `scan_en`=1 one start converts slots 0 to `reg_len` in ascending order, then stops when `cont_en`=0.
- R4: With `disc_en`=1 each start converts `disc_len`+1 regular slots (1 to 8) from the saved position. A burst ends early after slot `reg_len`, and the next start then begins at slot 0. Nothing runs between starts.
- R5: An injected start during a regular conversion drops that conversion and converts injected slots 0 to `inj_len`. The regular list then resumes at the dropped slot. `jeoc` is set when the injected run ends.
- R6: With `jdisc_en`=1 each injected start converts exactly one injected slot. The position advances from start to start and wraps after `inj_len`.
- R7: With `jauto_en`=1 the whole injected list runs after regular slot `reg_len` completes, with no injected start. Both external trigger lines are ignored in this mode.
- R8: An external line starts its list only on a low-to-high change and only while its enable (`ext_en` or `jext_en`) is 1. Holding a line high starts nothing more.
- R9: With each start, `adc_smp` carries the 3-bit code found at bits [3c+2:3c] of `smp_cfg`, where c is the channel being started.
- R10: A regular result is written to `reg_dr` and sets `eoc`. A `reg_rd` pulse clears `eoc`. A regular result that arrives while `eoc` is set and not being read sets `ovr`. `ovr_clr` clears `ovr`.
- R11: The result of injected slot k is written to field k of `inj_dr`, which is bits [12k+11:12k].
- R12: When `dma_en`=1 every regular result produces exactly one single-cycle `dma_req` pulse. When `dma_en`=0 there is none.
- R13: A `seq_wr` pulse drops the running conversion and discards its result. Both lists return to slot 0, and an active regular pass continues from slot 0 of the new list.
- R14: `irq` is (`eoc` AND `eoc_ie`) OR (`jeoc` AND `jeoc_ie`). `jeoc_clr` clears `jeoc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_en | input | 1 | Continuous mode for the regular list |
| scan_en | input | 1 | Scan mode: walk all regular slots |
| disc_en | input | 1 | Partial mode for the regular list |
| disc_len | input | 3 | Regular burst length minus one |
| jdisc_en | input | 1 | Partial mode for the injected list (one slot per start) |
| jauto_en | input | 1 | Run the injected list after each regular pass |
| dma_en | input | 1 | Enable transfer-request pulses |
| ext_en | input | 1 | Enable the regular external trigger |
| jext_en | input | 1 | Enable the injected external trigger |
| eoc_ie | input | 1 | Interrupt enable for `eoc` |
| jeoc_ie | input | 1 | Interrupt enable for `jeoc` |
| reg_len | input | 4 | Last regular slot index |
| inj_len | input | 2 | Last injected slot index |
| reg_seq | input | 80 | Regular slot channels, 5 bits per slot, slot 0 lowest |
| inj_seq | input | 20 | Injected slot channels, 5 bits per slot, slot 0 lowest |
| smp_cfg | input | 54 | Sampling-time code, 3 bits per channel, channel 0 lowest |
| seq_wr | input | 1 | List rewrite strobe (abort and restart) |
| sw_start | input | 1 | Software start for the regular list |
| jsw_start | input | 1 | Software start for the injected list |
| ext_trig | input | 1 | Selected regular external trigger line |
| jext_trig | input | 1 | Selected injected external trigger line |
| reg_rd | input | 1 | Regular result read strobe |
| ovr_clr | input | 1 | Clear overrun |
| jeoc_clr | input | 1 | Clear injected completion flag |
| adc_done | input | 1 | Conversion done pulse from the analog core |
| adc_data | input | 12 | Conversion result from the analog core |
| adc_start | output | 1 | Start strobe to the analog core |
| adc_ch | output | 5 | Channel to convert |
| adc_smp | output | 3 | Sampling-time code of that channel |
| reg_dr | output | 12 | Regular result register |
| inj_dr | output | 48 | Injected result registers, 12 bits per slot |
| eoc | output | 1 | Regular conversion complete |
| jeoc | output | 1 | Injected run complete |
| ovr | output | 1 | Regular result overwritten unread |
| dma_req | output | 1 | Transfer request pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench first checks pre-emption. It fires an injected start in the middle of a regular conversion and checks the full start order. A design that failed to resume would lose the interrupted slot, and one that advanced past it would skip a channel. Partial mode is exercised across three starts, so a wrong position hold or wrap shows up as repeated channels or an unwanted restart. The bench also holds an external line high, which catches a level-sensitive trigger. It rewrites the list mid-conversion and counts results: a design that stored the dropped conversion would give one result too many. Auto-injection is checked together with the masking of external triggers, and overrun is checked against unread back-to-back results.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REG, ST_INJ} conv_st_e;
  localparam int DISC_W   = 3;
  localparam int DISC_MAX = 8;
endpackage

// File: rtl/adcseq_edge.sv
module adcseq_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign rise[i] = lvl[i] & ~prev[i];
    // R8: a detected edge needs the line low one cycle before
    p_rise_needs_low_r8: assert property (@(posedge clk) disable iff (rst)
      rise[i] |-> !$past(lvl[i]));
  end
endmodule

// File: rtl/adcseq_core.sv
module adcseq_core
  import adcseq_pkg::*;
#(
  parameter int CH_W      = 5,
  parameter int NCH       = 18,
  parameter int SMP_W     = 3,
  parameter int REG_SLOTS = 16,
  parameter int INJ_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cont_en,
  input  logic                         scan_en,
  input  logic                         disc_en,
  input  logic [DISC_W-1:0]            disc_len,
  input  logic                         jdisc_en,
  input  logic                         jauto_en,
  input  logic [$clog2(REG_SLOTS)-1:0] reg_len,
  input  logic [$clog2(INJ_SLOTS)-1:0] inj_len,
  input  logic [REG_SLOTS*CH_W-1:0]    reg_seq,
  input  logic [INJ_SLOTS*CH_W-1:0]    inj_seq,
  input  logic [NCH*SMP_W-1:0]         smp_cfg,
  input  logic                         seq_wr,
  input  logic                         reg_go,
  input  logic                         inj_go,
  input  logic                         adc_done,
  output logic                         adc_start,
  output logic [CH_W-1:0]              adc_ch,
  output logic [SMP_W-1:0]             adc_smp,
  output logic                         reg_we,
  output logic                         inj_we,
  output logic [$clog2(INJ_SLOTS)-1:0] inj_idx,
  output logic                         inj_end
);
  localparam int RP_W = $clog2(REG_SLOTS);
  localparam int IP_W = $clog2(INJ_SLOTS);
  localparam int IL_W = $clog2(INJ_SLOTS + 1);
  localparam int RL_W = $clog2(DISC_MAX + 1);

  conv_st_e        st;
  logic [RP_W-1:0] rpos;
  logic [IP_W-1:0] ipos;
  logic            ract;
  logic [RL_W-1:0] rleft;
  logic [IL_W-1:0] ileft;
  logic [CH_W-1:0] reg_ch, inj_ch;
  logic [IL_W-1:0] iload;
  logic            inj_pend, r_last, i_last;

  assign reg_ch   = reg_seq[rpos*CH_W +: CH_W];
  assign inj_ch   = inj_seq[ipos*CH_W +: CH_W];
  assign inj_pend = (ileft != '0);
  assign r_last   = (!scan_en && !disc_en) || (rpos == reg_len);
  assign i_last   = (ipos == inj_len);
  assign iload    = jdisc_en ? IL_W'(1) : IL_W'(inj_len) + 1'b1;

  // result events to the storage side (a rewrite drops the pending result)
  assign reg_we  = (st == ST_REG) && adc_done && !seq_wr;
  assign inj_we  = (st == ST_INJ) && adc_done && !seq_wr;
  assign inj_idx = ipos;
  assign inj_end = (ileft == IL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rpos      <= '0;
      ipos      <= '0;
      ract      <= 1'b0;
      rleft     <= '0;
      ileft     <= '0;
      adc_start <= 1'b0;
      adc_ch    <= '0;
      adc_smp   <= '0;
    end else begin
      adc_start <= 1'b0;
      if (reg_go && !ract) begin
        ract  <= 1'b1;
        rleft <= disc_en ? RL_W'(disc_len) + 1'b1 : '0;
      end
      if (inj_go && !inj_pend) begin
        ileft <= iload;
        if (!jdisc_en) ipos <= '0;
      end
      if (seq_wr) begin
        st   <= ST_IDLE;
        rpos <= '0;
        ipos <= '0;
      end else begin
        case (st)
          ST_IDLE: begin
            if (inj_pend) begin
              adc_start <= 1'b1;
              adc_ch    <= inj_ch;
              adc_smp   <= smp_cfg[inj_ch*SMP_W +: SMP_W];
              st        <= ST_INJ;
            end else if (ract) begin
              adc_start <= 1'b1;
              adc_ch    <= reg_ch;
              adc_smp   <= smp_cfg[reg_ch*SMP_W +: SMP_W];
              st        <= ST_REG;
            end
          end
          ST_REG: begin
            if (adc_done) begin
              st   <= ST_IDLE;
              rpos <= r_last ? '0 : rpos + 1'b1;
              if (disc_en) begin
                rleft <= rleft - 1'b1;
                if (rleft == RL_W'(1) || r_last) ract <= 1'b0;
              end else if (r_last) begin
                ract <= cont_en;
              end
              if (r_last && jauto_en && !jdisc_en && !inj_pend) begin
                ileft <= iload;
                ipos  <= '0;
              end
            end else if (inj_go && !inj_pend) begin
              st <= ST_IDLE;  // pre-empt: slot position kept for resume
            end
          end
          ST_INJ: begin
            if (adc_done) begin
              st    <= ST_IDLE;
              ipos  <= i_last ? '0 : ipos + 1'b1;
              ileft <= ileft - 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: the start strobe lasts one cycle
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  // R5: pending injected work wins the converter over regular work
  p_inj_first_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && inj_pend && !seq_wr) |=> (st == ST_INJ && adc_start));
  // R4: a burst never exceeds the partial-mode limit
  p_disc_bound_r4: assert property (@(posedge clk) disable iff (rst)
    rleft <= RL_W'(DISC_MAX));
  // R6: partial injected mode never has more than one slot outstanding
  p_jdisc_one_r6: assert property (@(posedge clk) disable iff (rst)
    (jdisc_en && $past(jdisc_en)) |-> (ileft <= IL_W'(1)));
endmodule

// File: rtl/adcseq_store.sv
module adcseq_store #(
  parameter int RES_W     = 12,
  parameter int INJ_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic                         inj_we,
  input  logic [$clog2(INJ_SLOTS)-1:0] inj_idx,
  input  logic                         inj_end,
  input  logic [RES_W-1:0]             adc_data,
  input  logic                         reg_rd,
  input  logic                         ovr_clr,
  input  logic                         jeoc_clr,
  input  logic                         dma_en,
  input  logic                         eoc_ie,
  input  logic                         jeoc_ie,
  output logic [RES_W-1:0]             reg_dr,
  output logic [INJ_SLOTS*RES_W-1:0]   inj_dr,
  output logic                         eoc,
  output logic                         jeoc,
  output logic                         ovr,
  output logic                         dma_req,
  output logic                         irq
);
  logic [RES_W-1:0] inj_mem [INJ_SLOTS];
  logic eoc_n, jeoc_n, ovr_n;

  always_comb begin
    eoc_n  = reg_we | (eoc & ~reg_rd);
    ovr_n  = (reg_we & eoc & ~reg_rd) | (ovr & ~ovr_clr);
    jeoc_n = (inj_we & inj_end) | (jeoc & ~jeoc_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_dr  <= '0;
      eoc     <= 1'b0;
      jeoc    <= 1'b0;
      ovr     <= 1'b0;
      dma_req <= 1'b0;
      irq     <= 1'b0;
      for (int i = 0; i < INJ_SLOTS; i++) inj_mem[i] <= '0;
    end else begin
      if (reg_we) reg_dr <= adc_data;
      if (inj_we) inj_mem[inj_idx] <= adc_data;
      eoc     <= eoc_n;
      jeoc    <= jeoc_n;
      ovr     <= ovr_n;
      dma_req <= reg_we & dma_en;
      irq     <= (eoc_n & eoc_ie) | (jeoc_n & jeoc_ie);
    end
  end

  for (genvar k = 0; k < INJ_SLOTS; k++) begin : g_jdr
    assign inj_dr[k*RES_W +: RES_W] = inj_mem[k];
  end

  // R10: a read with no new result clears the flag
  p_rd_clears_eoc_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_we) |=> !eoc);
  // R10: an unread result being replaced raises overrun
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_we && eoc && !reg_rd) |=> ovr);
  // R12: the transfer request is a single-cycle pulse
  p_dma_single_r12: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);
  // R14: no interrupt without a set flag
  p_irq_flag_r14: assert property (@(posedge clk) disable iff (rst)
    irq |-> (eoc || jeoc));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W      = 5,
  parameter int NCH       = 18,
  parameter int SMP_W     = 3,
  parameter int RES_W     = 12,
  parameter int REG_SLOTS = 16,
  parameter int INJ_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cont_en,
  input  logic                         scan_en,
  input  logic                         disc_en,
  input  logic [2:0]                   disc_len,
  input  logic                         jdisc_en,
  input  logic                         jauto_en,
  input  logic                         dma_en,
  input  logic                         ext_en,
  input  logic                         jext_en,
  input  logic                         eoc_ie,
  input  logic                         jeoc_ie,
  input  logic [$clog2(REG_SLOTS)-1:0] reg_len,
  input  logic [$clog2(INJ_SLOTS)-1:0] inj_len,
  input  logic [REG_SLOTS*CH_W-1:0]    reg_seq,
  input  logic [INJ_SLOTS*CH_W-1:0]    inj_seq,
  input  logic [NCH*SMP_W-1:0]         smp_cfg,
  input  logic                         seq_wr,
  input  logic                         sw_start,
  input  logic                         jsw_start,
  input  logic                         ext_trig,
  input  logic                         jext_trig,
  input  logic                         reg_rd,
  input  logic                         ovr_clr,
  input  logic                         jeoc_clr,
  input  logic                         adc_done,
  input  logic [RES_W-1:0]             adc_data,
  output logic                         adc_start,
  output logic [CH_W-1:0]              adc_ch,
  output logic [SMP_W-1:0]             adc_smp,
  output logic [RES_W-1:0]             reg_dr,
  output logic [INJ_SLOTS*RES_W-1:0]   inj_dr,
  output logic                         eoc,
  output logic                         jeoc,
  output logic                         ovr,
  output logic                         dma_req,
  output logic                         irq
);
  localparam int IP_W = $clog2(INJ_SLOTS);

  logic [1:0]      rise;
  logic            reg_go, inj_go;
  logic            reg_we, inj_we, inj_end;
  logic [IP_W-1:0] inj_idx;

  adcseq_edge #(.N(2)) u_edge (
    .clk(clk), .rst(rst), .lvl({jext_trig, ext_trig}), .rise(rise)
  );

  // external lines are masked while the injected list follows the regular one
  assign reg_go = sw_start  | (ext_en  & ~jauto_en & rise[0]);
  assign inj_go = jsw_start | (jext_en & ~jauto_en & rise[1]);

  adcseq_core #(
    .CH_W(CH_W), .NCH(NCH), .SMP_W(SMP_W),
    .REG_SLOTS(REG_SLOTS), .INJ_SLOTS(INJ_SLOTS)
  ) u_core (
    .clk(clk), .rst(rst), .cont_en(cont_en), .scan_en(scan_en),
    .disc_en(disc_en), .disc_len(disc_len), .jdisc_en(jdisc_en),
    .jauto_en(jauto_en), .reg_len(reg_len), .inj_len(inj_len),
    .reg_seq(reg_seq), .inj_seq(inj_seq), .smp_cfg(smp_cfg),
    .seq_wr(seq_wr), .reg_go(reg_go), .inj_go(inj_go), .adc_done(adc_done),
    .adc_start(adc_start), .adc_ch(adc_ch), .adc_smp(adc_smp),
    .reg_we(reg_we), .inj_we(inj_we), .inj_idx(inj_idx), .inj_end(inj_end)
  );

  adcseq_store #(.RES_W(RES_W), .INJ_SLOTS(INJ_SLOTS)) u_store (
    .clk(clk), .rst(rst), .reg_we(reg_we), .inj_we(inj_we),
    .inj_idx(inj_idx), .inj_end(inj_end), .adc_data(adc_data),
    .reg_rd(reg_rd), .ovr_clr(ovr_clr), .jeoc_clr(jeoc_clr),
    .dma_en(dma_en), .eoc_ie(eoc_ie), .jeoc_ie(jeoc_ie),
    .reg_dr(reg_dr), .inj_dr(inj_dr), .eoc(eoc), .jeoc(jeoc),
    .ovr(ovr), .dma_req(dma_req), .irq(irq)
  );

  // R7: with auto-injection on, a rising external line alone starts nothing
  p_auto_masks_ext_r7: assert property (@(posedge clk) disable iff (rst)
    (jauto_en && !sw_start && !jsw_start) |-> (!reg_go && !inj_go));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // scan, disc, disc_len, reg_len, expected conversions per start
  localparam int VEC [NV][5] = '{
    '{0, 0, 0, 3, 1},   // R1
    '{1, 0, 0, 3, 4},   // R3
    '{1, 1, 1, 3, 2},   // R4
    '{0, 1, 7, 5, 6},   // R4 burst cut at end of list
    '{1, 0, 0, 0, 1}    // R3 single-slot list
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cont_en = 0, scan_en = 0, disc_en = 0, jdisc_en = 0, jauto_en = 0;
  logic dma_en = 0, ext_en = 0, jext_en = 0, eoc_ie = 0, jeoc_ie = 0;
  logic [2:0] disc_len = 0;
  logic [3:0] reg_len = 0;
  logic [1:0] inj_len = 0;
  logic [79:0] reg_seq = '0;
  logic [19:0] inj_seq = '0;
  logic [53:0] smp_cfg = '0;
  logic seq_wr = 0, sw_start = 0, jsw_start = 0, ext_trig = 0, jext_trig = 0;
  logic reg_rd = 0, ovr_clr = 0, jeoc_clr = 0;
  logic adc_done = 0;
  logic [11:0] adc_data = '0;
  logic adc_start;
  logic [4:0] adc_ch;
  logic [2:0] adc_smp;
  logic [11:0] reg_dr;
  logic [47:0] inj_dr;
  logic eoc, jeoc, ovr, dma_req, irq;

  int checks = 0;
  int fails = 0;
  int nstart = 0;
  int dma_cnt = 0;
  int log_ch [64];
  int log_smp [64];
  logic busy = 0;
  int cnt = 0;
  logic [4:0] cur = '0;

  adc_seq_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // analog core stand-in: a new start restarts it
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (rst) busy <= 1'b0;
    else if (adc_start) begin
      busy <= 1'b1; cnt <= 3 + int'(adc_smp); cur <= adc_ch;
    end else if (busy) begin
      if (cnt == 1) begin
        adc_done <= 1'b1; adc_data <= 12'(int'(cur) * 100 + 5); busy <= 1'b0;
      end
      cnt <= cnt - 1;
    end
  end

  always @(posedge clk) begin
    if (adc_start === 1'b1 && nstart < 64) begin
      log_ch[nstart] = int'(adc_ch);
      log_smp[nstart] = int'(adc_smp);
      nstart = nstart + 1;
    end
    if (dma_req === 1'b1) dma_cnt = dma_cnt + 1;
  end

  function automatic int f_ch(int r); return (3 * r + 1) % 12; endfunction
  function automatic int g_ch(int r); return (5 * r + 2) % 12; endfunction
  function automatic int dat(int ch); return ch * 100 + 5; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_seq(input bit alt);
    for (int r = 0; r < 16; r++) reg_seq[r*5 +: 5] = alt ? 5'(g_ch(r)) : 5'(f_ch(r));
    for (int r = 0; r < 4; r++) inj_seq[r*5 +: 5] = 5'(12 + r);
    for (int c = 0; c < 18; c++) smp_cfg[c*3 +: 3] = 3'(c % 8);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; nstart = 0; dma_cnt = 0;
  endtask

  task automatic pulse_sw();  @(negedge clk); sw_start = 1;  @(negedge clk); sw_start = 0;  endtask
  task automatic pulse_jsw(); @(negedge clk); jsw_start = 1; @(negedge clk); jsw_start = 0; endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic set_mode(input bit sc, input bit di, input int dl, input int rl);
    scan_en = sc; disc_en = di; disc_len = 3'(dl); reg_len = 4'(rl);
  endtask

  initial begin
    bit ok;
    load_seq(0);
    do_reset();
    idle(1);
    chk(eoc == 0 && jeoc == 0 && ovr == 0 && dma_req == 0 && irq == 0 && adc_start == 0
        && reg_dr == 0 && inj_dr == 0, "R10 reset state", int'(eoc), 0);

    // table-driven regular modes
    for (int v = 0; v < NV; v++) begin
      do_reset();
      set_mode(VEC[v][0] != 0, VEC[v][1] != 0, VEC[v][2], VEC[v][3]);
      dma_en = 1; eoc_ie = 1;
      pulse_sw();
      idle(150);
      chk(nstart == VEC[v][4], $sformatf("R3 R4 vec%0d count", v), nstart, VEC[v][4]);
      ok = 1;
      for (int k = 0; k < nstart; k++) if (log_ch[k] != f_ch(k)) ok = 0;
      chk(ok, $sformatf("R1 R3 vec%0d slot order", v), log_ch[0], f_ch(0));
      ok = 1;
      for (int k = 0; k < nstart; k++) if (log_smp[k] != log_ch[k] % 8) ok = 0;
      chk(ok, $sformatf("R9 vec%0d sample code", v), log_smp[0], log_ch[0] % 8);
      chk(eoc == 1 && int'(reg_dr) == dat(f_ch(VEC[v][4] - 1)),
          $sformatf("R10 vec%0d result", v), int'(reg_dr), dat(f_ch(VEC[v][4] - 1)));
      chk(int'(ovr) == int'(VEC[v][4] > 1), $sformatf("R10 vec%0d overrun", v), int'(ovr), int'(VEC[v][4] > 1));
      chk(dma_cnt == VEC[v][4], $sformatf("R12 vec%0d dma pulses", v), dma_cnt, VEC[v][4]);
      chk(irq == 1, $sformatf("R14 vec%0d irq", v), int'(irq), 1);
    end
    dma_en = 0;

    // read clears eoc and irq, ovr_clr clears overrun
    @(negedge clk); reg_rd = 1; @(negedge clk); reg_rd = 0; ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(eoc == 0 && irq == 0, "R10 R14 read clears flag", int'(eoc), 0);
    do_reset(); set_mode(0, 0, 0, 3);
    pulse_sw(); idle(40); pulse_sw(); idle(40);
    chk(ovr == 1, "R10 unread result overrun", int'(ovr), 1);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(ovr == 0, "R10 ovr_clr", int'(ovr), 0);

    // continuous
    do_reset(); set_mode(0, 0, 0, 3); cont_en = 1;
    pulse_sw(); idle(200);
    ok = (nstart >= 5);
    for (int k = 0; k < nstart; k++) if (log_ch[k] != f_ch(0)) ok = 0;
    chk(ok, "R2 continuous one-shot repeat", nstart, 5);
    do_reset(); set_mode(1, 0, 0, 2);
    pulse_sw(); idle(200);
    chk(nstart >= 5 && log_ch[3] == f_ch(0) && log_ch[4] == f_ch(1), "R2 scan wrap", log_ch[3], f_ch(0));
    cont_en = 0;

    // partial mode position carry
    do_reset(); set_mode(0, 1, 1, 2);
    pulse_sw(); idle(80);
    chk(nstart == 2 && log_ch[1] == f_ch(1), "R4 first burst", nstart, 2);
    pulse_sw(); idle(80);
    chk(nstart == 3 && log_ch[2] == f_ch(2), "R4 burst cut at end", nstart, 3);
    idle(100);
    chk(nstart == 3, "R4 no restart without start", nstart, 3);
    pulse_sw(); idle(80);
    chk(nstart == 5 && log_ch[3] == f_ch(0) && log_ch[4] == f_ch(1), "R4 wrap to slot 0", log_ch[3], f_ch(0));

    // injected pre-emption and resume
    do_reset(); set_mode(1, 0, 0, 3); inj_len = 1;
    pulse_sw();
    while (nstart < 2) @(negedge clk);
    idle(2);
    pulse_jsw(); idle(200);
    ok = (nstart == 7) && log_ch[0] == f_ch(0) && log_ch[1] == f_ch(1) && log_ch[2] == 12
         && log_ch[3] == 13 && log_ch[4] == f_ch(1) && log_ch[5] == f_ch(2) && log_ch[6] == f_ch(3);
    chk(ok, "R5 pre-empt and resume order", nstart, 7);
    chk(jeoc == 1, "R5 jeoc", int'(jeoc), 1);
    chk(int'(inj_dr[11:0]) == dat(12) && int'(inj_dr[23:12]) == dat(13), "R11 injected slots",
        int'(inj_dr[23:12]), dat(13));
    chk(int'(reg_dr) == dat(f_ch(3)), "R5 regular result after resume", int'(reg_dr), dat(f_ch(3)));
    @(negedge clk); reg_rd = 1; jeoc_ie = 1; @(negedge clk); reg_rd = 0; idle(1);
    chk(irq == 1, "R14 irq from jeoc", int'(irq), 1);
    @(negedge clk); jeoc_clr = 1; @(negedge clk); jeoc_clr = 0; idle(1);
    chk(jeoc == 0 && irq == 0, "R14 jeoc_clr", int'(jeoc), 0);
    jeoc_ie = 0;

    // injected partial mode
    do_reset(); set_mode(0, 0, 0, 0); inj_len = 2; jdisc_en = 1;
    for (int t = 0; t < 4; t++) begin pulse_jsw(); idle(50); end
    chk(nstart == 4 && log_ch[0] == 12 && log_ch[1] == 13 && log_ch[2] == 14 && log_ch[3] == 12,
        "R6 one slot per start", nstart, 4);
    jdisc_en = 0;

    // auto-injection and external masking
    do_reset(); set_mode(1, 0, 0, 1); inj_len = 1; jauto_en = 1;
    pulse_sw(); idle(150);
    chk(nstart == 4 && log_ch[1] == f_ch(1) && log_ch[2] == 12 && log_ch[3] == 13,
        "R7 auto injection", nstart, 4);
    nstart = 0; ext_en = 1; jext_en = 1;
    @(negedge clk); ext_trig = 1; jext_trig = 1; idle(100);
    chk(nstart == 0, "R7 externals ignored", nstart, 0);
    ext_trig = 0; jext_trig = 0; jauto_en = 0; jext_en = 0;

    // external edge sensitivity
    do_reset(); set_mode(0, 0, 0, 3); ext_en = 1;
    idle(2); ext_trig = 1; idle(100);
    chk(nstart == 1, "R8 held line starts once", nstart, 1);
    ext_trig = 0; idle(3); ext_trig = 1; idle(60);
    chk(nstart == 2, "R8 second rising edge", nstart, 2);
    chk(dma_cnt == 0, "R12 no pulses with dma off", dma_cnt, 0);
    ext_en = 0; ext_trig = 0; idle(3); ext_trig = 1; idle(60);
    chk(nstart == 2, "R8 disabled line", nstart, 2);
    ext_trig = 0;

    // list rewrite mid-conversion
    do_reset(); set_mode(1, 0, 0, 3); dma_en = 1;
    pulse_sw();
    while (nstart < 2) @(negedge clk);
    idle(2);
    load_seq(1); seq_wr = 1; @(negedge clk); seq_wr = 0;
    idle(200);
    ok = (nstart == 6) && log_ch[2] == g_ch(0) && log_ch[3] == g_ch(1) && log_ch[5] == g_ch(3);
    chk(ok, "R13 restart from new slot 0", nstart, 6);
    chk(dma_cnt == 5, "R13 aborted result discarded", dma_cnt, 5);
    chk(int'(reg_dr) == dat(g_ch(3)), "R13 final result", int'(reg_dr), dat(g_ch(3)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule